// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls one general-purpose I/O port of parameterised width (eight pins by default). A bus master reaches three registers through separate write strobes and read selects that share one write data bus and one read data bus. The direction register sets, for each pin, whether the pin drives or listens. The output latch holds the value that output pins drive. The port register returns the level present on the pins, after a synchronizer.

Each pin can also be taken over by a peripheral. A force-output request makes the pin drive the peripheral's data bit. A force-input request turns the driver off. Neither request changes the stored direction or latch contents. Software therefore always reads back what it wrote, even while a peripheral owns the pin.

The block has no state machine. Its state is the direction register, the output latch and the synchronizer chain. Writes take effect on a rising clock edge. Reads are combinational from the registers.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction register reads all ones, the output latch reads zero and every `pin_oe` bit is 0.
- R2: With no override on a pin, a direction bit of 1 makes `pin_oe` 0. A direction bit of 0 makes `pin_oe` 1, and `pin_out` then carries the latch bit. For example, direction 0xCF drives only bits 5:4.
- R3: A strobe on `wr_port` or on `wr_lat` loads `wdata` into the output latch at the next rising edge. Without either strobe the latch holds its value.
- R4: Reading with `rd_lat` returns the latch contents, not the pin levels.
- R5: Reading with `rd_port` returns `pin_in` through a two-flop synchronizer. A change of `pin_in` becomes visible on `rdata` after the second rising edge that follows the change.
- R6: Reading with `rd_dir` returns the stored direction value whatever the overrides are. The direction register changes only on a `wr_dir` strobe.
- R7: When `ovr_out_en` bit i is 1, `pin_oe` bit i is 1 and `pin_out` bit i equals `ovr_out_data` bit i. The latch keeps its stored value.
- R8: When `ovr_in_en` bit i is 1 and `ovr_out_en` bit i is 0, `pin_oe` bit i is 0 regardless of the direction bit.
- R9: When both override requests are set for one pin, force-output wins.
- R10: Read select priority is `rd_dir` over `rd_lat` over `rd_port`. With no select active, `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_dir | input | 1 | Write strobe, direction register |
| wr_port | input | 1 | Write strobe, port address (loads the latch) |
| wr_lat | input | 1 | Write strobe, latch address |
| wdata | input | W | Write data |
| rd_dir | input | 1 | Read select, direction register |
| rd_lat | input | 1 | Read select, output latch |
| rd_port | input | 1 | Read select, synchronized pin levels |
| rdata | output | W | Read data |
| pin_in | input | W | Raw pin levels |
| pin_out | output | W | Per-pin output data |
| pin_oe | output | W | Per-pin output enable, 1 = drive |
| ovr_out_en | input | W | Per-pin peripheral force-output |
| ovr_out_data | input | W | Per-pin peripheral output data |
| ovr_in_en | input | W | Per-pin peripheral force-input |

## Verification
The pin logic is tried with a set of direction, latch and override combinations. These cover a mixed direction pattern, all outputs, all inputs under a partial force-output, a force-input over output pins, both overrides on the same pins, and alternating patterns. Together they separate the pure direction decode from each override and from the override priority. Each combination also reads back the direction and latch registers, which shows that overrides do not disturb them. Directed tests then check the synchronizer latency one edge at a time, the difference between port and latch reads, and the read select priority.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_DIR  = 2'd1,
        RSEL_LAT  = 2'd2,
        RSEL_PORT = 2'd3
    } rd_sel_e;

    localparam int unsigned DIR_RESET_ONES = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic         wr_port,
    input  logic         wr_lat,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            lat_q <= '0;
        end else begin
            if (wr_dir)            dir_q <= wdata;
            if (wr_port || wr_lat) lat_q <= wdata;
        end
    end

    // R3: latch holds without a write strobe
    a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_port || wr_lat) |=> $stable(lat_q));

    // R6: direction only changes on its own strobe
    a_r6_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] ovr_out_en,
    input  logic [W-1:0] ovr_out_data,
    input  logic [W-1:0] ovr_in_en,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (ovr_out_en[i]) begin
                pin_oe[i]  = 1'b1;
                pin_out[i] = ovr_out_data[i];
            end else if (ovr_in_en[i]) begin
                pin_oe[i]  = 1'b0;
                pin_out[i] = lat_q[i];
            end else begin
                pin_oe[i]  = ~dir_q[i];
                pin_out[i] = lat_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic         wr_port,
    input  logic         wr_lat,
    input  logic [W-1:0] wdata,
    input  logic         rd_dir,
    input  logic         rd_lat,
    input  logic         rd_port,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    input  logic [W-1:0] ovr_out_en,
    input  logic [W-1:0] ovr_out_data,
    input  logic [W-1:0] ovr_in_en
);
    logic [W-1:0] dir_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] pin_sync;
    rd_sel_e      rsel;

    gpio_regs #(.W(W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dir  (wr_dir),
        .wr_port (wr_port),
        .wr_lat  (wr_lat),
        .wdata   (wdata),
        .dir_q   (dir_q),
        .lat_q   (lat_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    gpio_pin_mux #(.W(W)) mux_i (
        .dir_q        (dir_q),
        .lat_q        (lat_q),
        .ovr_out_en   (ovr_out_en),
        .ovr_out_data (ovr_out_data),
        .ovr_in_en    (ovr_in_en),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe)
    );

    always_comb begin
        if (rd_dir)       rsel = RSEL_DIR;
        else if (rd_lat)  rsel = RSEL_LAT;
        else if (rd_port) rsel = RSEL_PORT;
        else              rsel = RSEL_NONE;
    end

    always_comb begin
        unique case (rsel)
            RSEL_DIR:  rdata = dir_q;
            RSEL_LAT:  rdata = lat_q;
            RSEL_PORT: rdata = pin_sync;
            default:   rdata = '0;
        endcase
    end

    // R7, R9: a forced output pin is always enabled
    a_r7_force_out_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ovr_out_en) == ovr_out_en);

    // R7: forced output pin carries the peripheral bit
    a_r7_force_out_data: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ ovr_out_data) & ovr_out_en) == '0);

    // R8: forced input without forced output is never driven
    a_r8_force_in: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ovr_in_en & ~ovr_out_en) == '0);

    // R3: a latch write shows on non-overridden pins next cycle
    a_r3_write_to_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_port || wr_lat) |=> (((pin_out ^ $past(wdata)) & ~ovr_out_en) == '0));
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int NVEC = 6;

    // {dir, lat, ovr_out_en, ovr_out_data, ovr_in_en, exp_oe, exp_out}
    localparam logic [7*W-1:0] VECS [NVEC] = '{
        {8'hCF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h30, 8'hA5},
        {8'h00, 8'h3C, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h3C},
        {8'hFF, 8'h3C, 8'h0F, 8'h05, 8'h00, 8'h0F, 8'h35},
        {8'h00, 8'hFF, 8'h00, 8'h00, 8'hF0, 8'h0F, 8'hFF},
        {8'hFF, 8'h00, 8'h81, 8'h01, 8'h81, 8'h81, 8'h01},
        {8'h55, 8'hAA, 8'h00, 8'h00, 8'h0F, 8'hA0, 8'hAA}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic wr_dir = 0, wr_port = 0, wr_lat = 0;
    logic rd_dir = 0, rd_lat = 0, rd_port = 0;
    logic [W-1:0] wdata = '0, pin_in = '0;
    logic [W-1:0] ovr_out_en = '0, ovr_out_data = '0, ovr_in_en = '0;
    logic [W-1:0] rdata, pin_out, pin_oe;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ctrl #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_dir(wr_dir), .wr_port(wr_port), .wr_lat(wr_lat), .wdata(wdata),
        .rd_dir(rd_dir), .rd_lat(rd_lat), .rd_port(rd_port), .rdata(rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .ovr_out_en(ovr_out_en), .ovr_out_data(ovr_out_data), .ovr_in_en(ovr_in_en)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(int which, logic [W-1:0] d);
        @(negedge clk);
        wdata = d;
        wr_dir = (which == 0); wr_port = (which == 1); wr_lat = (which == 2);
        @(negedge clk);
        wr_dir = 0; wr_port = 0; wr_lat = 0;
    endtask

    task automatic bus_read(int which, output logic [W-1:0] d);
        rd_dir = (which == 0); rd_lat = (which == 1); rd_port = (which == 2);
        #1 d = rdata;
        rd_dir = 0; rd_lat = 0; rd_port = 0;
    endtask

    initial begin
        #(CLK_PERIOD*5000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        bus_read(0, r); check("R1 dir reset", r, 8'hFF);
        bus_read(1, r); check("R1 lat reset", r, 8'h00);
        check("R1 oe reset", pin_oe, 8'h00);
        rst_n = 1;
        @(negedge clk);

        // Vector table: R2, R6, R7, R8, R9
        for (int v = 0; v < NVEC; v++) begin
            logic [W-1:0] vd, vl, voo, vod, voi, eoe, eout;
            {vd, vl, voo, vod, voi, eoe, eout} = VECS[v];
            ovr_out_en = '0; ovr_out_data = '0; ovr_in_en = '0;
            bus_write(0, vd);
            bus_write(2, vl);
            ovr_out_en = voo; ovr_out_data = vod; ovr_in_en = voi;
            #1;
            check("R2/R7/R8/R9 pin_oe", pin_oe, eoe);
            check("R2/R7 pin_out", pin_out, eout);
            bus_read(0, r); check("R6 dir readback under override", r, vd);
            bus_read(1, r); check("R7 latch unchanged by override", r, vl);
        end
        ovr_out_en = '0; ovr_out_data = '0; ovr_in_en = '0;

        // R3: write via port address loads latch, hold otherwise
        bus_write(1, 8'h69);
        bus_read(1, r); check("R3 port write loads latch", r, 8'h69);
        @(negedge clk);
        bus_read(1, r); check("R3 latch holds", r, 8'h69);

        // R5: synchronizer latency
        pin_in = 8'h5A;
        bus_read(2, r); check("R5 before edges", r, 8'h00);
        @(negedge clk);
        bus_read(2, r); check("R5 after one edge", r, 8'h00);
        @(negedge clk);
        bus_read(2, r); check("R5 after two edges", r, 8'h5A);

        // R4: latch read differs from pin read
        bus_read(1, r); check("R4 latch not pins", r, 8'h69);

        // R10: read priority
        rd_dir = 1; rd_lat = 1; rd_port = 1; #1;
        check("R10 dir wins", rdata, 8'h55);
        rd_dir = 0; #1;
        check("R10 lat over port", rdata, 8'h69);
        rd_lat = 0; rd_port = 0; #1;
        check("R10 none selected", rdata, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule